// File: doc/BRIEF.md
# Power mode clock enable controller

This block sequences the clock enables of a processor subsystem across four operating modes: normal, idle, slow clock and standby. It leaves reset in slow clock mode, where the master clock is taken from the always-running 32.768 kHz slow clock and the main oscillator and PLL are switched off. Software moves the subsystem between modes by writing a mode command. Idle and standby gate the processor clock and are left only when an interrupt arrives or on reset.

A move from slow clock mode to normal mode is a handshake. The controller first requests the oscillator and waits for its ready flag. It then requests the PLL and waits for that ready flag. Only after both does it switch the master clock source select to the fast clock. A mode command written while one of these waits is running is held in a single pending slot, where the newest write replaces any older one. That command is applied on the cycle after the wake completes.

Peripheral clock enables live in a mask. The mask is changed through separate set and clear registers and read back through a status register. Two more enables control the USB device and USB host 48 MHz clocks. A build option adds a divide-by-2 stage on the path from the PLL to the USB clocks.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is slow clock. osc_en, pll_en and mclk_src_sel are 0. proc_clk_en is 1. The peripheral mask and both USB enables are 0. slow_clk_en and mclk_en are 1 in every mode.
- R2: A write to offset 0 sets every mask bit whose wdata bit is 1. A write to offset 1 clears every mask bit whose wdata bit is 1. Bit i of the mask belongs to peripheral i, and all other bits keep their value. A read of offset 2 returns the mask in the low bits, with zeros above.
- R3: periph_clk_en always equals the mask, in every mode including idle and standby.
- R4: In slow clock mode, writing mode command 0 (normal) to offset 3 has three steps, each on a clock edge. At the next edge osc_en rises. At the first edge where osc_ready is sampled high, pll_en rises. At the first later edge where pll_ready is sampled high, mclk_src_sel rises and the mode becomes normal. The mode reads as slow clock until that last edge.
- R5: A read of offset 3 returns the mode in bits [1:0] (0 normal, 1 idle, 2 slow clock, 3 standby). Bit 2 is 1 while a wake sequence runs. Bit 3 is 1 while a pending command is held.
- R6: In normal mode, command 1 enters idle at the next edge and drives proc_clk_en to 0. A cycle with irq_pending high in idle returns to normal at the next edge. In normal and slow clock modes, irq_pending has no effect.
- R7: In normal mode, command 2 enters slow clock mode at the next edge. At that edge mclk_src_sel, osc_en and pll_en all drop to 0.
- R8: Standby is entered at the next edge by command 3 from normal mode, or by command 1 or 3 from slow clock mode. In standby proc_clk_en, osc_en, pll_en and mclk_src_sel are 0. A cycle with irq_pending high in standby returns to slow clock mode.
- R9: Mode commands written while in idle or standby are ignored.
- R10: A command written during a wake sequence is held, and a later write replaces it. It is applied at the edge after the mode becomes normal.
- R11: Offset 4 holds the USB enables, bit 0 for the device clock and bit 1 for the host clock, and reads back as written. usb_dev_clk_en and usb_host_clk_en equal their bit ANDed with mclk_src_sel.
- R12: With USB_DIV2 = 1 (the default), usb_div2_en is 1 exactly when either USB clock enable output is 1. With USB_DIV2 = 0 it is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq_pending | input | 1 | Interrupt pending, wakes idle and standby |
| osc_ready | input | 1 | Main oscillator stable |
| pll_ready | input | 1 | PLL locked |
| slow_clk_en | output | 1 | Slow clock enable, always 1 |
| mclk_en | output | 1 | Master clock domain enable, always 1 |
| proc_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |
| usb_dev_clk_en | output | 1 | USB device 48 MHz clock enable |
| usb_host_clk_en | output | 1 | USB host 48 MHz clock enable |
| usb_div2_en | output | 1 | Enable for the divide-by-2 stage ahead of the USB clocks |
| osc_en | output | 1 | Main oscillator enable request |
| pll_en | output | 1 | PLL enable request |
| mclk_src_sel | output | 1 | Master clock source: 0 slow clock, 1 PLL |

## Verification
Every piece of state in this block shows at the ports within one cycle. A wrong mode shows at once on proc_clk_en and at offset 3. A sequencer stuck in a wait leaves osc_en or pll_en high with mclk_src_sel low, and sets the busy bit. A lost pending command shows as a missing mode change on the cycle after the wake completes. The bench steps the oscillator and PLL ready flags by hand, so every edge of the wake handshake is sampled in the cycle it should move and in the cycles it should hold.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL  = 2'd0,
      MODE_IDLE    = 2'd1,
      MODE_SLOW    = 2'd2,
      MODE_STANDBY = 2'd3
   } pm_mode_e;

   typedef enum logic [1:0] {
      SEQ_REST     = 2'd0,
      SEQ_WAIT_OSC = 2'd1,
      SEQ_WAIT_PLL = 2'd2
   } seq_state_e;

   localparam int unsigned OFS_PSET  = 0;
   localparam int unsigned OFS_PCLR  = 1;
   localparam int unsigned OFS_PSTAT = 2;
   localparam int unsigned OFS_MODE  = 3;
   localparam int unsigned OFS_USB   = 4;

   localparam int unsigned MODE_BUSY_BIT = 2;
   localparam int unsigned MODE_PEND_BIT = 3;

endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
   import pmc_pkg::*;
#(
   parameter int unsigned NUM_PERIPH = 8,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   input  pm_mode_e              mode,
   input  logic                  busy,
   input  logic                  pend_v,
   output logic [DATA_W-1:0]     rdata,
   output logic [NUM_PERIPH-1:0] periph_mask,
   output logic [1:0]            usb_bits,
   output logic                  cmd_wr,
   output pm_mode_e              cmd
);

   localparam logic [ADDR_W-1:0] A_PSET  = ADDR_W'(OFS_PSET);
   localparam logic [ADDR_W-1:0] A_PCLR  = ADDR_W'(OFS_PCLR);
   localparam logic [ADDR_W-1:0] A_PSTAT = ADDR_W'(OFS_PSTAT);
   localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
   localparam logic [ADDR_W-1:0] A_USB   = ADDR_W'(OFS_USB);

   logic [NUM_PERIPH-1:0] wmask;
   logic                  hit_set, hit_clr, hit_usb;

   assign wmask   = wdata[NUM_PERIPH-1:0];
   assign hit_set = wr_en && (addr == A_PSET);
   assign hit_clr = wr_en && (addr == A_PCLR);
   assign hit_usb = wr_en && (addr == A_USB);
   assign cmd_wr  = wr_en && (addr == A_MODE);
   assign cmd     = pm_mode_e'(wdata[1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         periph_mask <= '0;
      end else if (hit_set) begin
         periph_mask <= periph_mask | wmask;
      end else if (hit_clr) begin
         periph_mask <= periph_mask & ~wmask;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         usb_bits <= 2'b00;
      end else if (hit_usb) begin
         usb_bits <= wdata[1:0];
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_PSTAT: rdata[NUM_PERIPH-1:0] = periph_mask;
         A_MODE: begin
            rdata[1:0]           = mode;
            rdata[MODE_BUSY_BIT] = busy;
            rdata[MODE_PEND_BIT] = pend_v;
         end
         A_USB:   rdata[1:0] = usb_bits;
         default: rdata = '0;
      endcase
   end

   // R2: the mask moves only on a set or clear write
   p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_set || hit_clr) |=> $stable(periph_mask));

   // R11: the USB bits move only on a write to their offset
   p_usb_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_usb |=> $stable(usb_bits));

endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
   import pmc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cmd_wr,
   input  pm_mode_e cmd,
   input  logic     irq,
   input  logic     osc_ready,
   input  logic     pll_ready,
   output pm_mode_e mode,
   output logic     busy,
   output logic     pend_v,
   output logic     osc_en,
   output logic     pll_en,
   output logic     src_sel
);

   seq_state_e seq_q, seq_n;
   pm_mode_e   mode_q, mode_n;
   pm_mode_e   pend_q, pend_n;
   logic       pend_v_q, pend_v_n;
   logic       osc_q, osc_n, pll_q, pll_n, src_q, src_n;
   logic       eff_v;
   pm_mode_e   eff_cmd;

   // a fresh write wins over a held command
   always_comb begin
      eff_v   = 1'b0;
      eff_cmd = cmd;
      if (cmd_wr) begin
         eff_v = 1'b1;
      end else if (pend_v_q && seq_q == SEQ_REST) begin
         eff_v   = 1'b1;
         eff_cmd = pend_q;
      end
   end

   always_comb begin
      seq_n    = seq_q;
      mode_n   = mode_q;
      pend_n   = pend_q;
      pend_v_n = pend_v_q;
      osc_n    = osc_q;
      pll_n    = pll_q;
      src_n    = src_q;
      unique case (seq_q)
         SEQ_REST: begin
            pend_v_n = 1'b0;
            unique case (mode_q)
               MODE_NORMAL: begin
                  if (eff_v) begin
                     unique case (eff_cmd)
                        MODE_IDLE: mode_n = MODE_IDLE;
                        MODE_SLOW, MODE_STANDBY: begin
                           mode_n = eff_cmd;
                           src_n  = 1'b0;
                           osc_n  = 1'b0;
                           pll_n  = 1'b0;
                        end
                        default: mode_n = mode_q;
                     endcase
                  end
               end
               MODE_SLOW: begin
                  if (eff_v) begin
                     unique case (eff_cmd)
                        MODE_NORMAL: begin
                           seq_n = SEQ_WAIT_OSC;
                           osc_n = 1'b1;
                        end
                        MODE_IDLE, MODE_STANDBY: mode_n = MODE_STANDBY;
                        default: mode_n = mode_q;
                     endcase
                  end
               end
               MODE_IDLE: begin
                  if (irq) mode_n = MODE_NORMAL;
               end
               MODE_STANDBY: begin
                  if (irq) mode_n = MODE_SLOW;
               end
               default: mode_n = mode_q;
            endcase
         end
         SEQ_WAIT_OSC: begin
            if (osc_ready) begin
               seq_n = SEQ_WAIT_PLL;
               pll_n = 1'b1;
            end
            if (cmd_wr) begin
               pend_v_n = 1'b1;
               pend_n   = cmd;
            end
         end
         SEQ_WAIT_PLL: begin
            if (pll_ready) begin
               seq_n  = SEQ_REST;
               src_n  = 1'b1;
               mode_n = MODE_NORMAL;
            end
            if (cmd_wr) begin
               pend_v_n = 1'b1;
               pend_n   = cmd;
            end
         end
         default: seq_n = SEQ_REST;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_q    <= SEQ_REST;
         mode_q   <= MODE_SLOW;
         pend_q   <= MODE_NORMAL;
         pend_v_q <= 1'b0;
         osc_q    <= 1'b0;
         pll_q    <= 1'b0;
         src_q    <= 1'b0;
      end else begin
         seq_q    <= seq_n;
         mode_q   <= mode_n;
         pend_q   <= pend_n;
         pend_v_q <= pend_v_n;
         osc_q    <= osc_n;
         pll_q    <= pll_n;
         src_q    <= src_n;
      end
   end

   assign mode    = mode_q;
   assign busy    = (seq_q != SEQ_REST);
   assign pend_v  = pend_v_q;
   assign osc_en  = osc_q;
   assign pll_en  = pll_q;
   assign src_sel = src_q;

   // R4: the fast source is selected only while oscillator and PLL run
   p_src_needs_pll_r4: assert property (@(posedge clk) disable iff (!rst_n)
      src_q |-> (osc_q && pll_q));

   // R4: the PLL is requested only after the oscillator reported ready
   p_pll_after_osc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_q) |-> (osc_q && $past(osc_ready)));

   // R4: the source switches only after the PLL reported ready
   p_src_after_pll_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_q) |-> $past(pll_ready));

   // R7: slow clock and standby at rest keep oscillator and PLL off
   p_slow_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == MODE_SLOW || mode_q == MODE_STANDBY) && seq_q == SEQ_REST)
      |-> (!osc_q && !pll_q && !src_q));

   // R6, R9: idle is left only on an interrupt
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_IDLE && !irq) |=> (mode_q == MODE_IDLE));

   // R8: standby wakes to slow clock on an interrupt
   p_standby_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_STANDBY && irq) |=> (mode_q == MODE_SLOW));

endmodule

// File: rtl/pmc_gates.sv
module pmc_gates
   import pmc_pkg::*;
#(
   parameter int unsigned NUM_PERIPH = 8,
   parameter bit          USB_DIV2   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  pm_mode_e              mode,
   input  logic                  src_sel,
   input  logic [NUM_PERIPH-1:0] periph_mask,
   input  logic [1:0]            usb_bits,
   output logic                  slow_clk_en,
   output logic                  mclk_en,
   output logic                  proc_clk_en,
   output logic [NUM_PERIPH-1:0] periph_clk_en,
   output logic                  usb_dev_clk_en,
   output logic                  usb_host_clk_en,
   output logic                  usb_div2_en
);

   assign slow_clk_en = 1'b1;
   assign mclk_en     = 1'b1;
   assign proc_clk_en = (mode == MODE_NORMAL) || (mode == MODE_SLOW);

   for (genvar gi = 0; gi < NUM_PERIPH; gi++) begin : g_periph
      assign periph_clk_en[gi] = periph_mask[gi];
   end

   assign usb_dev_clk_en  = usb_bits[0] & src_sel;
   assign usb_host_clk_en = usb_bits[1] & src_sel;

   if (USB_DIV2) begin : g_div2
      assign usb_div2_en = usb_dev_clk_en | usb_host_clk_en;
   end else begin : g_nodiv
      assign usb_div2_en = 1'b0;
   end

   // R6, R8: a gated mode never runs the processor clock
   p_gated_proc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_IDLE || mode == MODE_STANDBY) |-> !proc_clk_en);

   // R11: the USB clocks need the PLL source
   p_usb_fast_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (usb_dev_clk_en || usb_host_clk_en) |-> src_sel);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int unsigned NUM_PERIPH = 8,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 32,
   parameter bit          USB_DIV2   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic                  irq_pending,
   input  logic                  osc_ready,
   input  logic                  pll_ready,
   output logic                  slow_clk_en,
   output logic                  mclk_en,
   output logic                  proc_clk_en,
   output logic [NUM_PERIPH-1:0] periph_clk_en,
   output logic                  usb_dev_clk_en,
   output logic                  usb_host_clk_en,
   output logic                  usb_div2_en,
   output logic                  osc_en,
   output logic                  pll_en,
   output logic                  mclk_src_sel
);

   if (NUM_PERIPH < 1 || NUM_PERIPH > DATA_W) begin : g_bad_periph
      $error("pwr_mode_ctrl: NUM_PERIPH must lie in 1..DATA_W");
   end
   if (DATA_W < 4) begin : g_bad_data
      $error("pwr_mode_ctrl: DATA_W must be at least 4");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("pwr_mode_ctrl: ADDR_W must be at least 3");
   end

   pm_mode_e              mode;
   pm_mode_e              cmd;
   logic                  cmd_wr, busy, pend_v;
   logic [NUM_PERIPH-1:0] periph_mask;
   logic [1:0]            usb_bits;

   pmc_regs #(
      .NUM_PERIPH (NUM_PERIPH),
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (bus_wr),
      .addr        (bus_addr),
      .wdata       (bus_wdata),
      .mode        (mode),
      .busy        (busy),
      .pend_v      (pend_v),
      .rdata       (bus_rdata),
      .periph_mask (periph_mask),
      .usb_bits    (usb_bits),
      .cmd_wr      (cmd_wr),
      .cmd         (cmd)
   );

   pmc_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr),
      .cmd       (cmd),
      .irq       (irq_pending),
      .osc_ready (osc_ready),
      .pll_ready (pll_ready),
      .mode      (mode),
      .busy      (busy),
      .pend_v    (pend_v),
      .osc_en    (osc_en),
      .pll_en    (pll_en),
      .src_sel   (mclk_src_sel)
   );

   pmc_gates #(
      .NUM_PERIPH (NUM_PERIPH),
      .USB_DIV2   (USB_DIV2)
   ) u_gates (
      .clk             (clk),
      .rst_n           (rst_n),
      .mode            (mode),
      .src_sel         (mclk_src_sel),
      .periph_mask     (periph_mask),
      .usb_bits        (usb_bits),
      .slow_clk_en     (slow_clk_en),
      .mclk_en         (mclk_en),
      .proc_clk_en     (proc_clk_en),
      .periph_clk_en   (periph_clk_en),
      .usb_dev_clk_en  (usb_dev_clk_en),
      .usb_host_clk_en (usb_host_clk_en),
      .usb_div2_en     (usb_div2_en)
   );

   // R3: peripheral enables keep the mask through every mode change
   p_periph_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != $past(mode) && !bus_wr) |-> $stable(periph_clk_en));

endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;

   localparam int NP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [3:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_pending = 1'b0;
   logic          osc_ready = 1'b0;
   logic          pll_ready = 1'b0;
   logic          slow_clk_en, mclk_en, proc_clk_en;
   logic [NP-1:0] periph_clk_en;
   logic          usb_dev_clk_en, usb_host_clk_en, usb_div2_en;
   logic          osc_en, pll_en, mclk_src_sel;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [NP-1:0] exp_mask = '0;
   logic [1:0]    exp_usb = '0;
   logic [31:0]   rv;

   always #10 clk = ~clk;

   pwr_mode_ctrl #(.NUM_PERIPH(NP), .ADDR_W(4), .DATA_W(32), .USB_DIV2(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pending(irq_pending),
      .osc_ready(osc_ready), .pll_ready(pll_ready), .slow_clk_en(slow_clk_en),
      .mclk_en(mclk_en), .proc_clk_en(proc_clk_en), .periph_clk_en(periph_clk_en),
      .usb_dev_clk_en(usb_dev_clk_en), .usb_host_clk_en(usb_host_clk_en),
      .usb_div2_en(usb_div2_en), .osc_en(osc_en), .pll_en(pll_en),
      .mclk_src_sel(mclk_src_sel)
   );

   // expected read value of the mode register
   function automatic logic [31:0] mode_word(input int m, input bit busy, input bit pend);
      return 32'(m) | (busy ? 32'h4 : 32'h0) | (pend ? 32'h8 : 32'h0);
   endfunction

   // expected USB outputs {host, dev, div2}
   function automatic logic [2:0] usb_outs(input logic [1:0] bits, input bit fast);
      logic [1:0] e;
      e = bits & {2{fast}};
      return {e[1], e[0], |e};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic irq_pulse();
      @(negedge clk);
      irq_pending = 1'b1;
      @(negedge clk);
      irq_pending = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd7522));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'd3, rv);
      chk("R1 mode after reset", rv, mode_word(2, 0, 0));
      chk("R1 osc/pll/src", {osc_en, pll_en, mclk_src_sel}, 3'b000);
      chk("R1 proc clock", proc_clk_en, 1'b1);
      chk("R1 mask", periph_clk_en, '0);
      chk("R1 usb", {usb_host_clk_en, usb_dev_clk_en}, 2'b00);
      chk("R1 slow/mclk", {slow_clk_en, mclk_en}, 2'b11);

      // R2 set/clear in slow clock mode
      wr(4'd0, 32'h0000_00A5); exp_mask = 8'hA5;
      wr(4'd1, 32'h0000_0081); exp_mask = 8'h24;
      rd(4'd2, rv);
      chk("R2 status readback", rv, 32'(exp_mask));
      chk("R3 enables follow mask", periph_clk_en, exp_mask);

      // R4 wake sequence with slow ready flags
      wr(4'd3, 32'h0);
      chk("R4 osc_en after command", {osc_en, pll_en, mclk_src_sel}, 3'b100);
      rd(4'd3, rv);
      chk("R5 busy during wait", rv, mode_word(2, 1, 0));
      repeat (3) @(negedge clk);
      chk("R4 pll waits for osc_ready", pll_en, 1'b0);
      osc_ready = 1'b1;
      @(negedge clk);
      chk("R4 pll_en after osc_ready", {osc_en, pll_en, mclk_src_sel}, 3'b110);
      // R10 two commands held during the wait, last one wins
      wr(4'd3, 32'h3);
      wr(4'd3, 32'h1);
      rd(4'd3, rv);
      chk("R10 pending held", rv, mode_word(2, 1, 1));
      chk("R4 src held before pll_ready", mclk_src_sel, 1'b0);
      pll_ready = 1'b1;
      @(negedge clk);
      rd(4'd3, rv);
      chk("R4 normal after pll_ready", rv, mode_word(0, 0, 1));
      chk("R4 src selected", mclk_src_sel, 1'b1);
      @(negedge clk);
      rd(4'd3, rv);
      chk("R10 pending idle applied", rv, mode_word(1, 0, 0));
      chk("R6 proc gated in idle", proc_clk_en, 1'b0);

      // R9 command ignored in idle, R6 wake on interrupt
      wr(4'd3, 32'h2);
      rd(4'd3, rv);
      chk("R9 idle ignores command", rv, mode_word(1, 0, 0));
      chk("R3 mask kept in idle", periph_clk_en, exp_mask);
      irq_pulse();
      rd(4'd3, rv);
      chk("R6 interrupt wakes idle", rv, mode_word(0, 0, 0));
      chk("R6 proc back on", proc_clk_en, 1'b1);
      irq_pulse();
      rd(4'd3, rv);
      chk("R6 interrupt no effect in normal", rv, mode_word(0, 0, 0));

      // random mask and USB traffic in normal mode
      for (int i = 0; i < 200; i++) begin
         logic [31:0] d;
         int op;
         d  = $urandom;
         op = int'($urandom % 3);
         if (op == 0) begin
            wr(4'd0, d); exp_mask = exp_mask | d[NP-1:0];
         end else if (op == 1) begin
            wr(4'd1, d); exp_mask = exp_mask & ~d[NP-1:0];
         end else begin
            wr(4'd4, d); exp_usb = d[1:0];
         end
         rd(4'd2, rv);
         chk("R2 random status", rv, 32'(exp_mask));
         chk("R3 random enables", periph_clk_en, exp_mask);
         chk("R11 R12 random usb", {usb_host_clk_en, usb_dev_clk_en, usb_div2_en},
             usb_outs(exp_usb, 1'b1));
      end

      // R11 USB readback and gating
      wr(4'd4, 32'h3); exp_usb = 2'b11;
      chk("R12 div2 with both", {usb_host_clk_en, usb_dev_clk_en, usb_div2_en}, 3'b111);
      wr(4'd4, 32'h1); exp_usb = 2'b01;
      rd(4'd4, rv);
      chk("R11 usb readback", rv, 32'h1);
      chk("R11 host off", {usb_host_clk_en, usb_dev_clk_en, usb_div2_en}, 3'b011);

      // R7 normal to slow clock
      wr(4'd3, 32'h2);
      rd(4'd3, rv);
      chk("R7 slow mode", rv, mode_word(2, 0, 0));
      chk("R7 osc/pll/src off", {osc_en, pll_en, mclk_src_sel}, 3'b000);
      chk("R11 usb off on slow clock", {usb_host_clk_en, usb_dev_clk_en, usb_div2_en}, 3'b000);
      rd(4'd4, rv);
      chk("R11 usb bits kept", rv, 32'h1);
      irq_pulse();
      rd(4'd3, rv);
      chk("R6 interrupt no effect in slow", rv, mode_word(2, 0, 0));

      // R8 standby from slow via idle command, R9 ignored, wake
      wr(4'd3, 32'h1);
      rd(4'd3, rv);
      chk("R8 standby from slow", rv, mode_word(3, 0, 0));
      chk("R8 proc gated", proc_clk_en, 1'b0);
      chk("R3 mask kept in standby", periph_clk_en, exp_mask);
      chk("R1 slow/mclk in standby", {slow_clk_en, mclk_en}, 2'b11);
      wr(4'd3, 32'h0);
      rd(4'd3, rv);
      chk("R9 standby ignores command", rv, mode_word(3, 0, 0));
      chk("R9 osc stays off", {osc_en, pll_en}, 2'b00);
      irq_pulse();
      rd(4'd3, rv);
      chk("R8 interrupt wakes to slow", rv, mode_word(2, 0, 0));
      wr(4'd3, 32'h3);
      rd(4'd3, rv);
      chk("R8 standby command from slow", rv, mode_word(3, 0, 0));
      irq_pulse();

      // R4 wake with ready flags already high
      wr(4'd3, 32'h0);
      chk("R4 fast wake step 1", {osc_en, pll_en, mclk_src_sel}, 3'b100);
      @(negedge clk);
      chk("R4 fast wake step 2", {osc_en, pll_en, mclk_src_sel}, 3'b110);
      @(negedge clk);
      chk("R4 fast wake done", {osc_en, pll_en, mclk_src_sel}, 3'b111);
      rd(4'd3, rv);
      chk("R4 mode normal", rv, mode_word(0, 0, 0));
      chk("R11 usb on with pll", {usb_host_clk_en, usb_dev_clk_en, usb_div2_en}, 3'b011);

      // R8 normal to standby
      wr(4'd3, 32'h3);
      rd(4'd3, rv);
      chk("R8 standby from normal", rv, mode_word(3, 0, 0));
      chk("R8 clocks off", {proc_clk_en, osc_en, pll_en, mclk_src_sel}, 4'b0000);
      irq_pulse();
      rd(4'd3, rv);
      chk("R8 wake to slow", rv, mode_word(2, 0, 0));

      finish_run();
   end

endmodule